// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

A countdown watchdog on a plain 32-bit register bus. Software loads a reload value, then restarts the timer by writing one fixed 16-bit key to a dedicated register. While running, the counter steps down either on an external 1 MHz tick enable or on every bus clock. When a step finds the count already at zero, the timer has expired. It then reloads and keeps running. It also raises a one-clock request on the reset output that the selected reset scope names, and can raise a one-clock external-pulse request.

Expiry also records sticky status. A timeout flag is always set. An alternate-boot flag is set when the control word arms it. A pre-timeout interrupt is raised when the upper count bits reach a threshold held in the upper part of the control word. The status bits stay set until software writes a 1 to bit 0 of the clear register. The external pulse shaping and the reset network itself sit outside this block.

Top module: `wdog_timer`

## Requirements
- R1: After reset the count, reload, control and status registers read 0, and irq, alt_boot and every request output are low.
- R2: A write of exactly 0x00004755 to offset 0x08 loads the count from the reload register (offset 0x04) at that clock edge. This takes priority over a step in the same cycle.
- R3: A write of any other value to offset 0x08 leaves the count unchanged, and so do writes to the read-only count register at offset 0x00 and writes to the reload register.
- R4: Control bit 0 runs the counter. With control bit 4 set, the counter steps only in cycles where tick_1mhz is high. With bit 4 clear, it steps every clock. With bit 0 clear, the count is frozen.
- R5: A step taken while the count is 0 is an expiry. The count reloads, status bit 0 is set, and the enabled requests are high for exactly the following clock. After a restart to value N, expiries fall on steps N+1, 2N+2, and so on.
- R6: On expiry with control bit 1 set, control bits 6:5 choose one output: 00 rst_req_soc, 01 rst_req_chip, 10 rst_req_cpu, 11 none. With bit 1 clear, none of the three rises.
- R7: On expiry with control bit 3 set, ext_pulse_req rises for one clock, whatever the value of bit 1.
- R8: While bits 0 and 2 of the control word are both set and count bits 31:10 equal control bits 31:10, status bit 2 and irq become set on the next clock and stay set. With bit 2 clear, irq stays low.
- R9: An expiry with control bit 7 set sets status bit 1 and alt_boot, and both stay set.
- R10: A write to offset 0x14 with bit 0 set clears status bits 2:0, irq and alt_boot. A write there with bit 0 clear changes nothing. A set event in the same cycle wins over the clear.
- R11: Reads return the count at 0x00, the reload value at 0x04, and the control word at 0x0C with bits 9:8 as zero. Status is returned at 0x10 in bits 2:0 (bit 2 pre-timeout, bit 1 alternate boot, bit 0 timeout). Offsets 0x08 and 0x14 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1mhz | input | 1 | One-cycle 1 MHz step enable |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq | output | 1 | Sticky pre-timeout interrupt |
| rst_req_soc | output | 1 | One-clock SoC reset request |
| rst_req_chip | output | 1 | One-clock full-chip reset request |
| rst_req_cpu | output | 1 | One-clock CPU-only reset request |
| ext_pulse_req | output | 1 | One-clock external reset pulse request |
| alt_boot | output | 1 | Sticky alternate-boot selection |

## Verification
The bench builds the block with its default 32-bit data path, 8-bit offsets and a threshold field starting at bit 10. It runs mostly with control bit 4 clear, so each clock is a step and reload values of two to four make expiry cheap. That lets it sweep all 32 combinations of reset scope, reset enable, external enable and alternate-boot arm, and compare every output on every clock against an arithmetic expiry schedule. A reload of 3000 with threshold 1 puts the pre-timeout crossing at an exactly computed cycle. Separate passes with hand-driven ticks cover the tick mode, freezing, and rejected restart keys.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

    localparam logic [7:0] OFF_COUNT   = 8'h00;
    localparam logic [7:0] OFF_RELOAD  = 8'h04;
    localparam logic [7:0] OFF_RESTART = 8'h08;
    localparam logic [7:0] OFF_CTRL    = 8'h0C;
    localparam logic [7:0] OFF_STATUS  = 8'h10;
    localparam logic [7:0] OFF_CLEAR   = 8'h14;

    localparam logic [15:0] RESTART_KEY    = 16'h4755;
    localparam logic [31:0] CTRL_RSVD_MASK = 32'h0000_0300;
    localparam int          NUM_SCOPES     = 3;

    typedef enum logic [1:0] {
        SCOPE_SOC  = 2'b00,
        SCOPE_CHIP = 2'b01,
        SCOPE_CPU  = 2'b10,
        SCOPE_NONE = 2'b11
    } scope_e;

    // low byte of the control word, msb first
    typedef struct packed {
        logic   alt_arm;
        scope_e scope;
        logic   tick_sel;
        logic   ext_en;
        logic   irq_en;
        logic   rst_en;
        logic   run;
    } ctrl_t;

    typedef struct packed {
        logic pre;
        logic alt;
        logic tmo;
    } status_t;

    function automatic logic key_match(input logic [31:0] d);
        return d == {16'h0000, RESTART_KEY};
    endfunction

endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] count,
    input  status_t           status,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] reload_q,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              restart_req,
    output logic              clear_req
);
    localparam logic [DATA_W-1:0] KEEP_MASK = ~DATA_W'(CTRL_RSVD_MASK);

    logic sel_reload, sel_restart, sel_ctrl, sel_clear;

    assign sel_reload  = bus_addr == ADDR_W'(OFF_RELOAD);
    assign sel_restart = bus_addr == ADDR_W'(OFF_RESTART);
    assign sel_ctrl    = bus_addr == ADDR_W'(OFF_CTRL);
    assign sel_clear   = bus_addr == ADDR_W'(OFF_CLEAR);

    assign restart_req = bus_we && sel_restart && key_match(32'(bus_wdata));
    assign clear_req   = bus_we && sel_clear && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            ctrl_q   <= '0;
        end else if (bus_we) begin
            if (sel_reload) reload_q <= bus_wdata;
            if (sel_ctrl)   ctrl_q   <= bus_wdata & KEEP_MASK;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFF_COUNT):  bus_rdata = count;
            ADDR_W'(OFF_RELOAD): bus_rdata = reload_q;
            ADDR_W'(OFF_CTRL):   bus_rdata = ctrl_q;
            ADDR_W'(OFF_STATUS): bus_rdata = DATA_W'(status);
            default:             bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick_sel,
    input  logic              tick,
    input  logic              restart,
    input  logic [DATA_W-1:0] reload,
    output logic [DATA_W-1:0] count_q,
    output logic              expire
);
    logic step;
    logic at_zero;

    assign step    = run && (tick_sel ? tick : 1'b1);
    assign at_zero = count_q == '0;
    assign expire  = step && at_zero && !restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (restart) begin
            count_q <= reload;
        end else if (step) begin
            count_q <= at_zero ? reload : count_q - 1'b1;
        end
    end
endmodule

// File: rtl/wdog_events.sv
`timescale 1ns/1ps
module wdog_events
    import wdog_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int THR_LSB = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  expire,
    input  logic                  clear,
    input  ctrl_t                 cfg,
    input  logic [DATA_W-1:0]     ctrl_word,
    input  logic [DATA_W-1:0]     count,
    output status_t               status_q,
    output logic [NUM_SCOPES-1:0] req_q,
    output logic                  ext_q
);
    localparam int THR_W = DATA_W - THR_LSB;

    logic [THR_W-1:0]      thr;
    logic [THR_W-1:0]      cnt_hi;
    logic                  pre_hit;
    logic [NUM_SCOPES-1:0] scope_hit;
    status_t               set_v;

    assign thr     = ctrl_word[DATA_W-1:THR_LSB];
    assign cnt_hi  = count[DATA_W-1:THR_LSB];
    assign pre_hit = cfg.run && cfg.irq_en && (cnt_hi == thr);

    for (genvar s = 0; s < NUM_SCOPES; s++) begin : g_scope
        assign scope_hit[s] = cfg.scope == scope_e'(s);
    end

    assign set_v.tmo = expire;
    assign set_v.alt = expire && cfg.alt_arm;
    assign set_v.pre = pre_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            req_q    <= '0;
            ext_q    <= 1'b0;
        end else begin
            status_q <= set_v | (clear ? status_t'('0) : status_q);
            req_q    <= (expire && cfg.rst_en) ? scope_hit : '0;
            ext_q    <= expire && cfg.ext_en;
        end
    end
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int THR_LSB = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1mhz,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req_soc,
    output logic              rst_req_chip,
    output logic              rst_req_cpu,
    output logic              ext_pulse_req,
    output logic              alt_boot
);
    logic [DATA_W-1:0]     count_q;
    logic [DATA_W-1:0]     reload_q;
    logic [DATA_W-1:0]     ctrl_q;
    logic                  restart_req;
    logic                  clear_req;
    logic                  expire;
    ctrl_t                 cfg;
    status_t               status_q;
    logic [NUM_SCOPES-1:0] req_q;

    assign cfg = ctrl_t'(ctrl_q[7:0]);

    wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .count       (count_q),
        .status      (status_q),
        .bus_rdata   (bus_rdata),
        .reload_q    (reload_q),
        .ctrl_q      (ctrl_q),
        .restart_req (restart_req),
        .clear_req   (clear_req)
    );

    wdog_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (cfg.run),
        .tick_sel (cfg.tick_sel),
        .tick     (tick_1mhz),
        .restart  (restart_req),
        .reload   (reload_q),
        .count_q  (count_q),
        .expire   (expire)
    );

    wdog_events #(.DATA_W(DATA_W), .THR_LSB(THR_LSB)) u_evt (
        .clk       (clk),
        .rst       (rst),
        .expire    (expire),
        .clear     (clear_req),
        .cfg       (cfg),
        .ctrl_word (ctrl_q),
        .count     (count_q),
        .status_q  (status_q),
        .req_q     (req_q),
        .ext_q     (ext_pulse_req)
    );

    assign rst_req_soc  = req_q[SCOPE_SOC];
    assign rst_req_chip = req_q[SCOPE_CHIP];
    assign rst_req_cpu  = req_q[SCOPE_CPU];
    assign irq          = status_q.pre;
    assign alt_boot     = status_q.alt;
endmodule

// File: rtl/wdog_checker.sv
`timescale 1ns/1ps
module wdog_checker
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] reload,
    input logic [DATA_W-1:0] ctrl,
    input logic              irq,
    input logic              rst_req_soc,
    input logic              rst_req_chip,
    input logic              rst_req_cpu,
    input logic              ext_pulse_req,
    input logic              alt_boot
);
    logic key_wr, bad_key_wr, clr_wr;

    assign key_wr     = bus_we && bus_addr == ADDR_W'(OFF_RESTART) && bus_wdata == DATA_W'(RESTART_KEY);
    assign bad_key_wr = bus_we && bus_addr == ADDR_W'(OFF_RESTART) && bus_wdata != DATA_W'(RESTART_KEY);
    assign clr_wr     = bus_we && bus_addr == ADDR_W'(OFF_CLEAR) && bus_wdata[0];

    AST_KEY_LOADS: assert property (@(posedge clk) disable iff (rst)
        key_wr |=> count == $past(reload)); // R2
    AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        bad_key_wr && !ctrl[0] |=> $stable(count)); // R3
    AST_STOPPED_FREEZES: assert property (@(posedge clk) disable iff (rst)
        !ctrl[0] && !key_wr |=> $stable(count)); // R4
    AST_ONE_SCOPE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rst_req_soc, rst_req_chip, rst_req_cpu})); // R6
    AST_SCOPE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (rst_req_soc || rst_req_chip || rst_req_cpu) |-> $past(ctrl[1])); // R6
    AST_EXT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        ext_pulse_req |-> $past(ctrl[3])); // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        irq && !clr_wr |=> irq); // R8
    AST_ALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        alt_boot && !clr_wr |=> alt_boot); // R9
endmodule

bind wdog_timer wdog_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_addr      (bus_addr),
    .bus_we        (bus_we),
    .bus_wdata     (bus_wdata),
    .count         (count_q),
    .reload        (reload_q),
    .ctrl          (ctrl_q),
    .irq           (irq),
    .rst_req_soc   (rst_req_soc),
    .rst_req_chip  (rst_req_chip),
    .rst_req_cpu   (rst_req_cpu),
    .ext_pulse_req (ext_pulse_req),
    .alt_boot      (alt_boot)
);

// File: tb/sim_wdog_timer.sv
`timescale 1ns/1ps
module sim_wdog_timer;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int THR_LSB = 10;
    localparam logic [31:0] KEY = 32'h0000_4755;
    localparam logic [7:0] A_CNT = 8'h00, A_REL = 8'h04, A_RST = 8'h08,
                           A_CTL = 8'h0C, A_STA = 8'h10, A_CLR = 8'h14;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_1mhz = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic irq, rst_req_soc, rst_req_chip, rst_req_cpu, ext_pulse_req, alt_boot;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wdog_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .THR_LSB(THR_LSB)) u0 (
        .clk(clk), .rst(rst), .tick_1mhz(tick_1mhz), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_req_soc(rst_req_soc), .rst_req_chip(rst_req_chip),
        .rst_req_cpu(rst_req_cpu), .ext_pulse_req(ext_pulse_req), .alt_boot(alt_boot)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic outs(output logic [31:0] v);
        v = {26'b0, alt_boot, irq, ext_pulse_req, rst_req_cpu, rst_req_chip, rst_req_soc};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, o, e;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_CNT, v); chk("R1 count", v, 0);
        rd(A_REL, v); chk("R1 reload", v, 0);
        rd(A_CTL, v); chk("R1 ctrl", v, 0);
        rd(A_STA, v); chk("R1 status", v, 0);
        outs(o);      chk("R1 outputs", o, 0);

        // R5 R6 R7 R9 R10: sweep scope, reset enable, ext enable, alt arm
        for (int c = 0; c < 32; c++) begin
            int r;
            logic [1:0] sc;
            logic ren, ext, alt;
            sc = c[1:0]; ren = c[2]; ext = c[3]; alt = c[4];
            r = 2 + (c % 3);
            wr(A_CTL, 0);
            wr(A_CLR, 1);
            wr(A_REL, r);
            wr(A_RST, KEY);
            wr(A_CTL, 32'(1) | (32'(ren) << 1) | (32'(ext) << 3) | (32'(sc) << 5) | (32'(alt) << 7));
            for (int k = 1; k <= 2 * (r + 1); k++) begin
                logic p;
                @(negedge clk);
                p = (k % (r + 1)) == 0;
                e = {26'b0, alt && (k >= r + 1), 1'b0, p && ext,
                     p && ren && sc == 2'b10, p && ren && sc == 2'b01, p && ren && sc == 2'b00};
                outs(o);
                chk($sformatf("R5 R6 R7 R9 c=%0d k=%0d", c, k), o, e);
            end
            wr(A_CTL, 0);
            rd(A_STA, v); chk($sformatf("R5 R9 status c=%0d", c), v, {30'b0, alt, 1'b1});
            wr(A_CLR, 0);
            rd(A_STA, v); chk($sformatf("R10 clear0 c=%0d", c), v, {30'b0, alt, 1'b1});
            wr(A_CLR, 1);
            rd(A_STA, v); chk($sformatf("R10 clear1 c=%0d", c), v, 0);
            chk("R10 alt_boot low", {31'b0, alt_boot}, 0);
        end

        // R4 tick mode, every-clock mode, freeze
        wr(A_REL, 100);
        wr(A_RST, KEY);
        wr(A_CTL, 32'h11);
        repeat (10) @(negedge clk);
        rd(A_CNT, v); chk("R4 no tick no step", v, 100);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk); tick_1mhz = 1'b1;
            @(negedge clk); tick_1mhz = 1'b0;
        end
        rd(A_CNT, v); chk("R4 tick steps", v, 93);
        wr(A_CTL, 32'h1);
        rd(A_CNT, v); chk("R4 switch edge", v, 93);
        repeat (5) @(negedge clk);
        rd(A_CNT, v); chk("R4 every clock", v, 88);
        wr(A_CTL, 0);
        rd(A_CNT, v); chk("R4 stop", v, 86);
        repeat (20) @(negedge clk);
        rd(A_CNT, v); chk("R4 frozen", v, 86);

        // R2 R3 restart key
        wr(A_RST, 32'h0000_4756);
        rd(A_CNT, v); chk("R3 wrong key", v, 86);
        wr(A_RST, 32'h0001_4755);
        rd(A_CNT, v); chk("R3 upper bits set", v, 86);
        wr(A_CNT, 32'h1234);
        rd(A_CNT, v); chk("R3 count write", v, 86);
        wr(A_REL, 32'h55);
        rd(A_CNT, v); chk("R3 reload write", v, 86);
        wr(A_RST, KEY);
        rd(A_CNT, v); chk("R2 key loads", v, 32'h55);

        // R8 pre-timeout, threshold 1 -> count 1024..2047
        wr(A_CLR, 1);
        wr(A_REL, 3000);
        wr(A_RST, KEY);
        wr(A_CTL, (32'd1 << THR_LSB) | 32'h5);
        for (int k = 1; k <= 2100; k++) begin
            @(negedge clk);
            if (k == 953)  chk("R8 before threshold", {31'b0, irq}, 0);
            if (k == 954)  chk("R8 at threshold", {31'b0, irq}, 1);
            if (k == 2100) chk("R8 sticky", {31'b0, irq}, 1);
        end
        rd(A_STA, v); chk("R8 status bit2", v, 32'h4);
        wr(A_CTL, 0);
        wr(A_CLR, 1);
        chk("R10 irq cleared", {31'b0, irq}, 0);
        wr(A_RST, KEY);
        wr(A_CTL, (32'd1 << THR_LSB) | 32'h1);
        repeat (1200) @(negedge clk);
        chk("R8 disabled irq", {31'b0, irq}, 0);
        wr(A_CTL, 0);

        // R11 read map
        wr(A_CTL, 32'hFFFF_FFFE);
        rd(A_CTL, v); chk("R11 ctrl", v, 32'hFFFF_FCFE);
        rd(A_REL, v); chk("R11 reload", v, 3000);
        rd(A_RST, v); chk("R11 restart reads 0", v, 0);
        rd(A_CLR, v); chk("R11 clear reads 0", v, 0);
        wr(A_CTL, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule